// File: doc/BRIEF.md
# Dual-Pipe Banked SRAM Scheduler

This block sits in front of a banked on-chip SRAM of sixteen 256-bit banks. It accepts two request streams with valid/ready handshakes. One stream carries reads, each with bank, row, column and tag. The other carries writes, each with bank, row, column and 256-bit data. In each cycle the block tries to issue one read and one write together, so the storage can move 256 bits in each direction per cycle.

Each bank keeps its own turnaround timers. They separate successive operations to that bank by a minimum gap that depends on the pair of operations: read then read, read then write, write then read, and write then write. The gaps come from wait-state inputs, so the balance between peak throughput and sensitivity to awkward access patterns can be retuned.

A read may be held back by its timer, or by a row clash with the write. In either case the write pipe still issues, and the reverse also holds. Read data comes back on a fixed two-cycle return path. Three counters classify every cycle as dual-issue, single-issue or idle.

Top module: `bank_sched`

## Requirements
- R1: Data written to bank b, row r, column c (the per-bank word address is {row, column}) is returned unchanged by a later read of the same bank, row and column.
- R2: When both pipes are eligible and do not clash, the read and the write issue in the same cycle, counted as one dual-issue cycle.
- R3: A read and a write to the same bank and the same row never issue in the same cycle.
- R4: An operation to a bank issues no earlier than G cycles after the previous operation to that bank. G is gap_rar for read after read, gap_war for write after read, gap_raw for read after write and gap_waw for write after write. A gap of 0 or 1 allows the next cycle. A pipe blocked this way does not block the other pipe.
- R5: On a row clash the write issues and the read waits, unless the read is starved.
- R6: A read that has lost a clash in 4 consecutive clash cycles wins the next clash. Its loss count restarts from zero each time a read issues.
- R7: ret_valid, ret_tag and ret_data appear exactly 2 cycles after the cycle in which the read handshake occurs, in issue order, carrying the request's tag.
- R8: A read and a write to the same bank but different rows may dual-issue. That bank then accepts nothing for gap_pen extra cycles beyond its normal gaps.
- R9: Every cycle out of reset increments exactly one of cnt_dual (both issued), cnt_single (one issued) and cnt_idle (none issued).
- R10: Thirty-two writes walk banks 0 to 15 twice, and thirty-two reads walk banks two ahead, all at row 0, column 0, with gaps 16/2/15/16 and gap_pen 0. The run then completes with exactly 30 dual-issue and 4 single-issue cycles.
- R11: During reset both ready outputs are low, and after reset ret_valid and all three counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_bank | input | 4 | Read bank |
| rd_row | input | 2 | Read row |
| rd_col | input | 2 | Read column |
| rd_tag | input | 4 | Read tag returned with data |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request accepted this cycle |
| wr_bank | input | 4 | Write bank |
| wr_row | input | 2 | Write row |
| wr_col | input | 2 | Write column |
| wr_data | input | 256 | Write data |
| ret_valid | output | 1 | Read data valid |
| ret_tag | output | 4 | Tag of returned read |
| ret_data | output | 256 | Returned read data |
| gap_rar | input | 6 | Read-after-read gap |
| gap_war | input | 6 | Write-after-read gap |
| gap_raw | input | 6 | Read-after-write gap |
| gap_waw | input | 6 | Write-after-write gap |
| gap_pen | input | 6 | Extra block after same-bank different-row dual issue |
| cnt_dual | output | 32 | Dual-issue cycle count |
| cnt_single | output | 32 | Single-issue cycle count |
| cnt_idle | output | 32 | Idle cycle count |

## Verification
Row-clash arbitration and the turnaround timers can both decide the same cycle. A request can be timer-eligible and clash with the other pipe, or be blocked by its timer while the other pipe issues. The bench provokes clashes by holding both pipes on one bank and row with unit gaps, then reads the ready pattern cycle by cycle to see write priority and the fifth-cycle read win. Timer gating is provoked through same-bank pairs and the two-ahead walk. There the expected 30 dual and 4 single cycles prove that a timer-blocked pipe never held back the other.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    ISSUE_NONE   = 2'd0,
    ISSUE_SINGLE = 2'd1,
    ISSUE_DUAL   = 2'd2
  } issue_kind_e;

  function automatic issue_kind_e classify_issue(input logic rd_go, input logic wr_go);
    if (rd_go && wr_go) return ISSUE_DUAL;
    if (rd_go || wr_go) return ISSUE_SINGLE;
    return ISSUE_NONE;
  endfunction

endpackage

// File: rtl/bank_timer.sv
module bank_timer #(
  parameter int GAP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_hit,
  input  logic             wr_hit,
  input  logic             pen_hit,
  input  logic [GAP_W-1:0] gap_rar,
  input  logic [GAP_W-1:0] gap_war,
  input  logic [GAP_W-1:0] gap_raw,
  input  logic [GAP_W-1:0] gap_waw,
  input  logic [GAP_W-1:0] gap_pen,
  output logic             rd_open,
  output logic             wr_open
);
  localparam int CW = GAP_W + 1;

  // cycles still to wait after this one, so a gap G loads G-1
  function automatic logic [CW-1:0] reload(input logic [GAP_W-1:0] g, input logic [CW-1:0] extra);
    logic [CW-1:0] base;
    base = (g == '0) ? '0 : ({1'b0, g} - CW'(1));
    return base + extra;
  endfunction

  function automatic logic [CW-1:0] bigger(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [CW-1:0] rd_cnt, wr_cnt, rd_nxt, wr_nxt, extra;

  always_comb begin
    extra  = pen_hit ? {1'b0, gap_pen} : '0;
    rd_nxt = (rd_cnt == '0) ? '0 : rd_cnt - CW'(1);
    wr_nxt = (wr_cnt == '0) ? '0 : wr_cnt - CW'(1);
    if (rd_hit) begin
      rd_nxt = bigger(rd_nxt, reload(gap_rar, extra));
      wr_nxt = bigger(wr_nxt, reload(gap_war, extra));
    end
    if (wr_hit) begin
      rd_nxt = bigger(rd_nxt, reload(gap_raw, extra));
      wr_nxt = bigger(wr_nxt, reload(gap_waw, extra));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
    end else begin
      rd_cnt <= rd_nxt;
      wr_cnt <= wr_nxt;
    end
  end

  assign rd_open = (rd_cnt == '0);
  assign wr_open = (wr_cnt == '0);
endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
  parameter int AW = 4,
  parameter int DW = 256
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/issue_arb.sv
module issue_arb #(
  parameter int STARVE = 4,
  localparam int SW = $clog2(STARVE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_valid,
  input  logic          wr_valid,
  input  logic          rd_open_sel,
  input  logic          wr_open_sel,
  input  logic          same_bank,
  input  logic          same_row,
  output logic          rd_fire,
  output logic          wr_fire,
  output logic          clash,
  output logic [SW-1:0] starve_q
);
  logic rd_ok, wr_ok, starved;

  assign rd_ok   = !rst && rd_valid && rd_open_sel;
  assign wr_ok   = !rst && wr_valid && wr_open_sel;
  assign clash   = rd_ok && wr_ok && same_bank && same_row;
  assign starved = (starve_q >= SW'(STARVE));
  assign rd_fire = rd_ok && (!clash || starved);
  assign wr_fire = wr_ok && (!clash || !starved);

  always_ff @(posedge clk) begin
    if (rst || rd_fire) starve_q <= '0;
    else if (clash && !starved) starve_q <= starve_q + SW'(1);
  end
endmodule

// File: rtl/bank_sched.sv
module bank_sched #(
  parameter int NB     = 16,
  parameter int DW     = 256,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 2,
  parameter int TAG_W  = 4,
  parameter int GAP_W  = 6,
  parameter int CNT_W  = 32,
  parameter int STARVE = 4,
  localparam int BANK_W = $clog2(NB),
  localparam int AW     = ROW_W + COL_W,
  localparam int SW     = $clog2(STARVE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [COL_W-1:0]  rd_col,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DW-1:0]     wr_data,
  output logic              ret_valid,
  output logic [TAG_W-1:0]  ret_tag,
  output logic [DW-1:0]     ret_data,
  input  logic [GAP_W-1:0]  gap_rar,
  input  logic [GAP_W-1:0]  gap_war,
  input  logic [GAP_W-1:0]  gap_raw,
  input  logic [GAP_W-1:0]  gap_waw,
  input  logic [GAP_W-1:0]  gap_pen,
  output logic [CNT_W-1:0]  cnt_dual,
  output logic [CNT_W-1:0]  cnt_single,
  output logic [CNT_W-1:0]  cnt_idle
);
  import sched_pkg::*;

  logic [NB-1:0] rd_open, wr_open;
  logic [DW-1:0] bank_q [NB];
  logic          rd_open_sel, wr_open_sel, rd_fire, wr_fire, clash, pen_hit;
  logic [SW-1:0] starve_q;

  assign rd_open_sel = rd_open[rd_bank];
  assign wr_open_sel = wr_open[wr_bank];
  // only a different-row pair can reach the same bank together
  assign pen_hit     = rd_fire && wr_fire && (rd_bank == wr_bank);

  issue_arb #(.STARVE(STARVE)) u_arb (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .wr_valid(wr_valid),
    .rd_open_sel(rd_open_sel), .wr_open_sel(wr_open_sel),
    .same_bank(rd_bank == wr_bank), .same_row(rd_row == wr_row),
    .rd_fire(rd_fire), .wr_fire(wr_fire), .clash(clash), .starve_q(starve_q)
  );

  assign rd_ready = rd_fire;
  assign wr_ready = wr_fire;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic rd_here, wr_here;
    assign rd_here = rd_fire && (rd_bank == BANK_W'(g));
    assign wr_here = wr_fire && (wr_bank == BANK_W'(g));

    bank_timer #(.GAP_W(GAP_W)) u_timer (
      .clk(clk), .rst(rst), .rd_hit(rd_here), .wr_hit(wr_here),
      .pen_hit(pen_hit && rd_here),
      .gap_rar(gap_rar), .gap_war(gap_war), .gap_raw(gap_raw),
      .gap_waw(gap_waw), .gap_pen(gap_pen),
      .rd_open(rd_open[g]), .wr_open(wr_open[g])
    );

    sram_bank #(.AW(AW), .DW(DW)) u_ram (
      .clk(clk), .we(wr_here), .waddr({wr_row, wr_col}), .wdata(wr_data),
      .re(rd_here), .raddr({rd_row, rd_col}), .rdata(bank_q[g])
    );
  end

  // return path: bank register, then output register
  logic              s1_valid;
  logic [TAG_W-1:0]  s1_tag;
  logic [BANK_W-1:0] s1_bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      ret_valid <= 1'b0;
    end else begin
      s1_valid  <= rd_fire;
      ret_valid <= s1_valid;
    end
    s1_tag   <= rd_tag;
    s1_bank  <= rd_bank;
    ret_tag  <= s1_tag;
    ret_data <= bank_q[s1_bank];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_dual   <= '0;
      cnt_single <= '0;
      cnt_idle   <= '0;
    end else begin
      unique case (classify_issue(rd_fire, wr_fire))
        ISSUE_DUAL:   cnt_dual   <= cnt_dual + CNT_W'(1);
        ISSUE_SINGLE: cnt_single <= cnt_single + CNT_W'(1);
        default:      cnt_idle   <= cnt_idle + CNT_W'(1);
      endcase
    end
  end
endmodule

// File: rtl/bank_sched_chk.sv
module bank_sched_chk #(
  parameter int BANK_W = 4,
  parameter int ROW_W  = 2,
  parameter int SW     = 3,
  parameter int STARVE = 4,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_valid,
  input logic              wr_valid,
  input logic              rd_fire,
  input logic              wr_fire,
  input logic              rd_open_sel,
  input logic              wr_open_sel,
  input logic [BANK_W-1:0] rd_bank,
  input logic [BANK_W-1:0] wr_bank,
  input logic [ROW_W-1:0]  rd_row,
  input logic [ROW_W-1:0]  wr_row,
  input logic [SW-1:0]     starve_q,
  input logic              ret_valid,
  input logic [CNT_W-1:0]  cnt_dual,
  input logic [CNT_W-1:0]  cnt_single,
  input logic [CNT_W-1:0]  cnt_idle
);
  logic [CNT_W+1:0] cnt_sum;
  logic             row_clash_req;

  assign cnt_sum = {2'b00, cnt_dual} + {2'b00, cnt_single} + {2'b00, cnt_idle};
  assign row_clash_req = rd_valid && wr_valid && rd_open_sel && wr_open_sel &&
                         (rd_bank == wr_bank) && (rd_row == wr_row);

  assert_no_row_clash_R3: assert property (@(posedge clk) disable iff (rst)
    !(rd_fire && wr_fire && (rd_bank == wr_bank) && (rd_row == wr_row)));

  assert_read_timer_R4: assert property (@(posedge clk) disable iff (rst)
    rd_fire |-> rd_open_sel);

  assert_write_timer_R4: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> wr_open_sel);

  assert_write_first_R5: assert property (@(posedge clk) disable iff (rst)
    (row_clash_req && (starve_q < SW'(STARVE))) |-> (wr_fire && !rd_fire));

  assert_starve_bound_R6: assert property (@(posedge clk) disable iff (rst)
    starve_q <= SW'(STARVE));

  assert_return_delay_R7: assert property (@(posedge clk) disable iff (rst)
    ret_valid == $past(rd_fire, 2));

  assert_one_counter_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt_sum == $past(cnt_sum) + 1));
endmodule

bind bank_sched bank_sched_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .SW(SW), .STARVE(STARVE), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .wr_valid(wr_valid),
  .rd_fire(rd_fire), .wr_fire(wr_fire),
  .rd_open_sel(rd_open_sel), .wr_open_sel(wr_open_sel),
  .rd_bank(rd_bank), .wr_bank(wr_bank), .rd_row(rd_row), .wr_row(wr_row),
  .starve_q(starve_q), .ret_valid(ret_valid),
  .cnt_dual(cnt_dual), .cnt_single(cnt_single), .cnt_idle(cnt_idle)
);

// File: tb/bank_sched_test.sv
`timescale 1ns/1ps
module bank_sched_test;
  localparam int DW = 256;

  logic           clk = 1'b0;
  logic           rst;
  logic           rd_valid, rd_ready, wr_valid, wr_ready, ret_valid;
  logic [3:0]     rd_bank, wr_bank, rd_tag, ret_tag;
  logic [1:0]     rd_row, rd_col, wr_row, wr_col;
  logic [DW-1:0]  wr_data, ret_data;
  logic [5:0]     gap_rar, gap_war, gap_raw, gap_waw, gap_pen;
  logic [31:0]    cnt_dual, cnt_single, cnt_idle;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  bank_sched uut (
    .clk(clk), .rst(rst),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_bank(rd_bank), .rd_row(rd_row),
    .rd_col(rd_col), .rd_tag(rd_tag),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_bank(wr_bank), .wr_row(wr_row),
    .wr_col(wr_col), .wr_data(wr_data),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_data(ret_data),
    .gap_rar(gap_rar), .gap_war(gap_war), .gap_raw(gap_raw), .gap_waw(gap_waw),
    .gap_pen(gap_pen),
    .cnt_dual(cnt_dual), .cnt_single(cnt_single), .cnt_idle(cnt_idle)
  );

  typedef struct packed {
    logic [3:0]  bank;
    logic [1:0]  row;
    logic [1:0]  col;
    logic [31:0] seed;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{bank: 4'd0,  row: 2'd0, col: 2'd0, seed: 32'h0000_1111},
    '{bank: 4'd15, row: 2'd3, col: 2'd3, seed: 32'hDEAD_0001},
    '{bank: 4'd7,  row: 2'd1, col: 2'd2, seed: 32'h0BAD_F00D},
    '{bank: 4'd7,  row: 2'd2, col: 2'd2, seed: 32'h1234_5678},
    '{bank: 4'd3,  row: 2'd0, col: 2'd1, seed: 32'hCAFE_0042},
    '{bank: 4'd12, row: 2'd3, col: 2'd0, seed: 32'h5555_AAAA}
  };

  function automatic logic [DW-1:0] data_of(input logic [31:0] seed);
    logic [DW-1:0] d;
    for (int k = 0; k < 8; k++) d[k*32 +: 32] = seed * 32'h9E37_79B1 + 32'(k) * 32'h0101_0101;
    return d;
  endfunction

  task automatic check(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic set_gaps(input int rar, input int war, input int raw, input int waw, input int pen);
    gap_rar = 6'(rar); gap_war = 6'(war); gap_raw = 6'(raw); gap_waw = 6'(waw); gap_pen = 6'(pen);
  endtask

  task automatic do_reset();
    rst = 1'b1; rd_valid = 1'b0; wr_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic put_wr(input logic [3:0] b, input logic [1:0] r, input logic [1:0] c,
                        input logic [DW-1:0] d);
    wr_bank = b; wr_row = r; wr_col = c; wr_data = d;
  endtask

  task automatic put_rd(input logic [3:0] b, input logic [1:0] r, input logic [1:0] c,
                        input logic [3:0] t);
    rd_bank = b; rd_row = r; rd_col = c; rd_tag = t;
  endtask

  task automatic wr_op(input vec_t v);
    @(posedge clk); #1;
    put_wr(v.bank, v.row, v.col, data_of(v.seed));
    wr_valid = 1'b1;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1 wr_valid = 1'b0;
  endtask

  task automatic rd_check(input vec_t v, input logic [3:0] t);
    @(posedge clk); #1;
    put_rd(v.bank, v.row, v.col, t);
    rd_valid = 1'b1;
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    @(posedge clk); #1 rd_valid = 1'b0;
    @(negedge clk);
    check("R7", "ret_valid one cycle after issue", DW'(ret_valid), DW'(0));
    @(negedge clk);
    check("R7", "ret_valid two cycles after issue", DW'(ret_valid), DW'(1));
    check("R7", "ret_tag", DW'(ret_tag), DW'(t));
    check("R1", "ret_data", ret_data, data_of(v.seed));
  endtask

  // first op to bank b, then second op raised the next cycle; k = cycles until second issues
  task automatic gap_meas(input bit first_wr, input bit second_wr, input logic [3:0] b,
                          output int k);
    @(posedge clk); #1;
    put_wr(b, 2'd0, 2'd0, '0);
    put_rd(b, 2'd0, 2'd0, 4'd0);
    if (first_wr) wr_valid = 1'b1; else rd_valid = 1'b1;
    @(negedge clk);
    while (!(first_wr ? wr_ready : rd_ready)) @(negedge clk);
    @(posedge clk); #1;
    wr_valid = 1'b0; rd_valid = 1'b0;
    if (second_wr) wr_valid = 1'b1; else rd_valid = 1'b1;
    k = 1;
    @(negedge clk);
    while (!(second_wr ? wr_ready : rd_ready)) begin
      k++;
      @(negedge clk);
    end
    @(posedge clk); #1 wr_valid = 1'b0; rd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int k;
    logic [31:0] idle0;
    put_wr(4'd0, 2'd0, 2'd0, '0);
    put_rd(4'd0, 2'd0, 2'd0, 4'd0);
    set_gaps(16, 2, 15, 16, 0);

    // R11: ready low during reset even with requests present
    rst = 1'b1; rd_valid = 1'b1; wr_valid = 1'b1;
    repeat (2) @(negedge clk);
    check("R11", "rd_ready in reset", DW'(rd_ready), DW'(0));
    check("R11", "wr_ready in reset", DW'(wr_ready), DW'(0));
    @(posedge clk); #1 rd_valid = 1'b0; wr_valid = 1'b0; rst = 1'b0;
    @(negedge clk);
    check("R11", "ret_valid after reset", DW'(ret_valid), DW'(0));
    check("R11", "cnt_dual after reset", DW'(cnt_dual), DW'(0));
    check("R11", "cnt_single after reset", DW'(cnt_single), DW'(0));

    // R1 R7: table of write/read-back vectors with unit gaps
    set_gaps(1, 1, 1, 1, 0);
    do_reset();
    for (int i = 0; i < NVEC; i++) wr_op(VEC[i]);
    for (int i = 0; i < NVEC; i++) rd_check(VEC[i], 4'(i + 3));

    // R4: default gaps per operation pair
    set_gaps(16, 2, 15, 16, 0);
    do_reset(); gap_meas(1'b0, 1'b0, 4'd2, k);
    check("R4", "read after read gap", DW'(k), DW'(16));
    do_reset(); gap_meas(1'b0, 1'b1, 4'd9, k);
    check("R4", "write after read gap", DW'(k), DW'(2));
    do_reset(); gap_meas(1'b1, 1'b0, 4'd7, k);
    check("R4", "read after write gap", DW'(k), DW'(15));
    do_reset(); gap_meas(1'b1, 1'b1, 4'd4, k);
    check("R4", "write after write gap", DW'(k), DW'(16));
    // R4: reprogrammed gaps
    set_gaps(0, 2, 5, 16, 0);
    do_reset(); gap_meas(1'b1, 1'b0, 4'd11, k);
    check("R4", "reprogrammed read after write gap", DW'(k), DW'(5));
    do_reset(); gap_meas(1'b0, 1'b0, 4'd11, k);
    check("R4", "zero read after read gap", DW'(k), DW'(1));

    // R2 R10: ideal two-ahead walk with default gaps
    set_gaps(16, 2, 15, 16, 0);
    do_reset();
    @(posedge clk); #1;
    fork
      begin
        for (int i = 0; i < 32; i++) begin
          put_wr(4'(i % 16), 2'd0, 2'd0, data_of(32'(i)));
          wr_valid = 1'b1;
          @(negedge clk);
          while (!wr_ready) @(negedge clk);
          @(posedge clk); #1;
        end
        wr_valid = 1'b0;
      end
      begin
        for (int i = 0; i < 32; i++) begin
          put_rd(4'((i + 2) % 16), 2'd0, 2'd0, 4'(i));
          rd_valid = 1'b1;
          @(negedge clk);
          while (!rd_ready) @(negedge clk);
          @(posedge clk); #1;
        end
        rd_valid = 1'b0;
      end
    join
    @(negedge clk);
    check("R10", "dual-issue cycles in ideal walk", DW'(cnt_dual), DW'(30));
    check("R10", "single-issue cycles in ideal walk", DW'(cnt_single), DW'(4));
    // R9: idle cycles counted with no requests
    idle0 = cnt_idle;
    repeat (10) @(negedge clk);
    check("R9", "idle cycle increment", DW'(cnt_idle - idle0), DW'(10));
    check("R9", "dual count unchanged when idle", DW'(cnt_dual), DW'(30));

    // R5 R6: row clash with unit gaps; write wins 4 times, then read, then write again
    set_gaps(1, 1, 1, 1, 0);
    do_reset();
    @(posedge clk); #1;
    put_wr(4'd5, 2'd0, 2'd0, data_of(32'h77));
    put_rd(4'd5, 2'd0, 2'd1, 4'd9);
    wr_valid = 1'b1; rd_valid = 1'b1;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (n == 4) begin
        check("R6", $sformatf("rd_ready clash cycle %0d", n), DW'(rd_ready), DW'(1));
        check("R6", $sformatf("wr_ready clash cycle %0d", n), DW'(wr_ready), DW'(0));
      end else begin
        check("R5", $sformatf("rd_ready clash cycle %0d", n), DW'(rd_ready), DW'(0));
        check("R5", $sformatf("wr_ready clash cycle %0d", n), DW'(wr_ready), DW'(1));
      end
    end
    @(posedge clk); #1 wr_valid = 1'b0; rd_valid = 1'b0;

    // R8: same bank, different rows dual-issue, then gap_pen extra cycles blocked
    set_gaps(1, 1, 1, 1, 3);
    do_reset();
    @(posedge clk); #1;
    put_wr(4'd3, 2'd0, 2'd2, data_of(32'h99));
    put_rd(4'd3, 2'd1, 2'd2, 4'd1);
    wr_valid = 1'b1; rd_valid = 1'b1;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      check("R8", $sformatf("rd_ready penalty cycle %0d", n), DW'(rd_ready),
            DW'((n == 0 || n == 4) ? 1 : 0));
      check("R8", $sformatf("wr_ready penalty cycle %0d", n), DW'(wr_ready),
            DW'((n == 0 || n == 4) ? 1 : 0));
    end
    @(posedge clk); #1 wr_valid = 1'b0; rd_valid = 1'b0;
    @(negedge clk);
    check("R2", "dual count after penalty pairs", DW'(cnt_dual), DW'(2));

    finish_up();
  end
endmodule